// File: doc/BRIEF.md
# Microprogram Sequencer with Address-Selected Test Slots

This block steps through a 256-word microprogram ROM. It drives the control field of the current microword to a datapath. Each 20-bit word holds a 12-bit control field above an 8-bit next-address field. Words at addresses below 0x80 always continue to their next-address field. The low nibble of any address at 0x80 or above picks one of fifteen external test flags, and that nibble decides what the word does. One group of nibble codes makes the sequencer hold its address until the selected flag is true. The other group makes a two-way branch: one bit of the next address, fixed for each flag, is replaced by the flag's value.

The ROM image is a parameter, so each application supplies its own microprogram. A control field of all ones acts as a no-operation word, and chains of such words make short delays. The next address is computed from the flags present at the rising clock edge. The ROM is read synchronously at that next address, so the address and the control field change on the same edge. A per-slot polarity parameter lets any flag be taken as active low. Decoding the control field into strobes is left to the datapath.

Top module: `mseq_top`

## Requirements
- R1: While `rst` is high at a clock edge, `upc_o` becomes 0x00 and `ctrl_o` becomes the control field of word 0x00. The first edge with `rst` low executes word 0x00.
- R2: `ctrl_o` always equals the upper 12 bits of the ROM word at the address shown on `upc_o`, and both change on the same clock edge.
- R3: At any address from 0x00 to 0x7F, whatever its low nibble, the next address is the lower 8 bits of the word, and no test flag is consulted.
- R4: At addresses 0x80 and above, low nibble 0 waits on `cyc15_i`, 1 on `hcyc7_i`, 3 on `host_stb_i`, 7 on `sync_found_i`, 8 on `host_req_i`, 9 on `sector_found_i`, A on `sector_pulse_i`, C on `hcyc12_i` and D on `hcyc7_i`. When the flag is high at an edge, the sequencer moves to the next-address field.
- R5: While the flag of a wait slot is low, `upc_o` and `ctrl_o` stay unchanged on every edge.
- R6: If a wait slot's flag is already high on the first edge at that slot, the sequencer leaves it on that edge, with no stall cycle.
- R7: At addresses 0x80 and above, low nibble 2 branches on `drive_wr_i` using bit 4, 4 on `crc_zero_i` using bit 0, 5 on `addr_sel_i` using bit 5, 6 on `addr_eq_i` using bit 3, B on `cache_end_i` using bit 1, E on `cmd_ok_i` using bit 6, and F on `format_i` using bit 2. The target is the next-address field with that one bit changed.
- R8: The branch bit is set equal to the flag: a low flag clears that bit even when it is set in the next-address field, and a high flag sets it.
- R9: Flags other than the one selected by the current slot have no effect on the next address, in both wait and branch slots.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous active-high reset |
| cyc15_i | input | 1 | 15-count cycle flag (wait nibble 0) |
| hcyc7_i | input | 1 | Half-cycle-7 flag (wait nibbles 1 and D) |
| host_stb_i | input | 1 | Host strobe (wait nibble 3) |
| sync_found_i | input | 1 | Read sync found (wait nibble 7) |
| host_req_i | input | 1 | Host request (wait nibble 8) |
| sector_found_i | input | 1 | Sector found (wait nibble 9) |
| sector_pulse_i | input | 1 | Sector pulse (wait nibble A) |
| hcyc12_i | input | 1 | Half-cycle-12 flag (wait nibble C) |
| drive_wr_i | input | 1 | Drive write (branch nibble 2, bit 4) |
| crc_zero_i | input | 1 | CRC is zero (branch nibble 4, bit 0) |
| addr_sel_i | input | 1 | Address select (branch nibble 5, bit 5) |
| addr_eq_i | input | 1 | Address equal (branch nibble 6, bit 3) |
| cache_end_i | input | 1 | End of cache (branch nibble B, bit 1) |
| cmd_ok_i | input | 1 | Command valid (branch nibble E, bit 6) |
| format_i | input | 1 | Format command (branch nibble F, bit 2) |
| ctrl_o | output | 12 | Control field of the current microword |
| upc_o | output | 8 | Current microprogram address |

## Verification
The bench keeps the default 8-bit address, 12-bit control field and all-active-high polarity. It replaces the ROM image with a walking program. In that program, address 0x00 enters slot 0x80, and each slot 0x80+n lands on low addresses that lead into slot 0x80+n+1. Each control field is derived from its own address, so every `ctrl_o` value can be tied back to `upc_o`. One walk therefore visits all sixteen slot codes and both targets of every branch. Two branch fields (slots 4 and F) already have their branch bit set, which exposes a design that ORs the flag in instead of forcing the bit. Landing addresses such as 0x13 and 0x1A carry slot nibbles below 0x80, which shows that the top address bit gates all testing.

// File: rtl/mseq_pkg.sv
package mseq_pkg;

  localparam int SLOTS = 16;

  // Slot codes that stall rather than branch
  function automatic logic slot_is_wait(input logic [3:0] nib);
    case (nib)
      4'h2, 4'h4, 4'h5, 4'h6, 4'hB, 4'hE, 4'hF: return 1'b0;
      default: return 1'b1;
    endcase
  endfunction

  // Next-address bit replaced by a branch slot's flag
  function automatic logic [2:0] slot_branch_bit(input logic [3:0] nib);
    case (nib)
      4'h2: return 3'd4;
      4'h4: return 3'd0;
      4'h5: return 3'd5;
      4'h6: return 3'd3;
      4'hB: return 3'd1;
      4'hE: return 3'd6;
      4'hF: return 3'd2;
      default: return 3'd0;
    endcase
  endfunction

endpackage

// File: rtl/mseq_rom.sv
module mseq_rom #(
  parameter int AW = 8,
  parameter int CW = 12,
  parameter logic [(2**AW)*(CW+AW)-1:0] IMAGE = '0
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [AW-1:0]     addr,
  output logic [CW+AW-1:0]  q
);
  localparam int DEPTH = 2**AW;
  localparam int WW    = CW + AW;

  logic [WW-1:0] mem [DEPTH];

  initial begin
    for (int i = 0; i < DEPTH; i++) mem[i] = IMAGE[i*WW +: WW];
  end

  // single synchronous read port; reset just redirects the address
  always_ff @(posedge clk) begin
    q <= mem[rst ? '0 : addr];
  end
endmodule

// File: rtl/mseq_next.sv
module mseq_next
  import mseq_pkg::*;
#(
  parameter int                AW  = 8,
  parameter logic [SLOTS-1:0]  POL = '1
) (
  input  logic [AW-1:0]    pc,
  input  logic [AW-1:0]    field,
  input  logic [SLOTS-1:0] raw,
  output logic [SLOTS-1:0] eff,
  output logic [AW-1:0]    nxt
);
  // per-slot polarity: 1 = flag active high
  for (genvar k = 0; k < SLOTS; k++) begin : g_pol
    if (POL[k]) begin : g_hi
      assign eff[k] = raw[k];
    end else begin : g_lo
      assign eff[k] = ~raw[k];
    end
  end

  logic [3:0] nib;
  logic       hit;
  assign nib = pc[3:0];
  assign hit = eff[nib];

  always_comb begin
    nxt = field;
    if (pc[AW-1]) begin
      if (slot_is_wait(nib)) begin
        if (!hit) nxt = pc;
      end else begin
        nxt[slot_branch_bit(nib)] = hit;
      end
    end
  end
endmodule

// File: rtl/mseq_top.sv
module mseq_top
  import mseq_pkg::*;
#(
  parameter int                          AW        = 8,
  parameter int                          CW        = 12,
  parameter logic [SLOTS-1:0]            POL       = '1,
  parameter logic [(2**AW)*(CW+AW)-1:0]  ROM_IMAGE = {(2**AW){{CW{1'b1}}, {AW{1'b0}}}}
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          cyc15_i,
  input  logic          hcyc7_i,
  input  logic          host_stb_i,
  input  logic          sync_found_i,
  input  logic          host_req_i,
  input  logic          sector_found_i,
  input  logic          sector_pulse_i,
  input  logic          hcyc12_i,
  input  logic          drive_wr_i,
  input  logic          crc_zero_i,
  input  logic          addr_sel_i,
  input  logic          addr_eq_i,
  input  logic          cache_end_i,
  input  logic          cmd_ok_i,
  input  logic          format_i,
  output logic [CW-1:0] ctrl_o,
  output logic [AW-1:0] upc_o
);
  localparam int WW = CW + AW;

  logic [SLOTS-1:0] slot_raw;
  logic [SLOTS-1:0] slot_eff;
  logic [AW-1:0]    pc_q;
  logic [AW-1:0]    nxt;
  logic [WW-1:0]    word_q;

  // index = low nibble of the slot address
  assign slot_raw = {format_i, cmd_ok_i, hcyc7_i, hcyc12_i,
                     cache_end_i, sector_pulse_i, sector_found_i, host_req_i,
                     sync_found_i, addr_eq_i, addr_sel_i, crc_zero_i,
                     host_stb_i, drive_wr_i, hcyc7_i, cyc15_i};

  mseq_next #(.AW(AW), .POL(POL)) u_next (
    .pc    (pc_q),
    .field (word_q[AW-1:0]),
    .raw   (slot_raw),
    .eff   (slot_eff),
    .nxt   (nxt)
  );

  mseq_rom #(.AW(AW), .CW(CW), .IMAGE(ROM_IMAGE)) u_rom (
    .clk  (clk),
    .rst  (rst),
    .addr (nxt),
    .q    (word_q)
  );

  always_ff @(posedge clk) begin
    if (rst) pc_q <= '0;
    else     pc_q <= nxt;
  end

  assign ctrl_o = word_q[WW-1:AW];
  assign upc_o  = pc_q;
endmodule

// File: rtl/mseq_chk.sv
module mseq_chk
  import mseq_pkg::*;
#(
  parameter int AW = 8,
  parameter int CW = 12
) (
  input logic             clk,
  input logic             rst,
  input logic [AW-1:0]    upc,
  input logic [CW-1:0]    ctrl,
  input logic [AW-1:0]    field,
  input logic [SLOTS-1:0] eff
);
  logic is_slot, is_wait, hit;
  assign is_slot = upc[AW-1];
  assign is_wait = slot_is_wait(upc[3:0]);
  assign hit     = eff[upc[3:0]];

  // R3: low region always follows the stored field
  p_low_uncond_r3: assert property (@(posedge clk) disable iff (rst)
    !is_slot |=> upc == $past(field));

  // R5: a wait slot with a false flag holds address and control
  p_stall_hold_r5: assert property (@(posedge clk) disable iff (rst)
    (is_slot && is_wait && !hit) |=> ($stable(upc) && $stable(ctrl)));

  // R4: a wait slot with a true flag takes its field
  p_wait_release_r4: assert property (@(posedge clk) disable iff (rst)
    (is_slot && is_wait && hit) |=> upc == $past(field));

  // R7: a branch target differs from the field in at most one bit
  p_branch_onebit_r7: assert property (@(posedge clk) disable iff (rst)
    (is_slot && !is_wait) |=> $countones(upc ^ $past(field)) <= 1);
endmodule

bind mseq_top mseq_chk #(.AW(AW), .CW(CW)) u_chk (
  .clk   (clk),
  .rst   (rst),
  .upc   (upc_o),
  .ctrl  (ctrl_o),
  .field (word_q[AW-1:0]),
  .eff   (slot_eff)
);

// File: tb/sim_mseq_top.sv
`timescale 1ns/1ps
module sim_mseq_top;
  localparam int AW = 8;
  localparam int CW = 12;
  localparam int WW = AW + CW;
  localparam int DEPTH = 256;

  function automatic logic is_w(input int n);
    return !(n == 2 || n == 4 || n == 5 || n == 6 || n == 11 || n == 14 || n == 15);
  endfunction
  function automatic int bbit(input int n);
    case (n)
      2: return 4;  4: return 0;  5: return 5;  6: return 3;
      11: return 1; 14: return 6; 15: return 2;
      default: return 0;
    endcase
  endfunction
  function automatic logic [7:0] bbase(input int n);
    case (n)
      2: return 8'h20;  4: return 8'h41;  5: return 8'h50;  6: return 8'h60;
      11: return 8'h44; 14: return 8'h0E; 15: return 8'h2C;
      default: return 8'h00;
    endcase
  endfunction
  function automatic logic [11:0] fctl(input logic [7:0] a);
    return {a[3:0], a};
  endfunction
  function automatic logic [7:0] bexp(input int n, input logic v);
    logic [7:0] t;
    t = bbase(n);
    t[bbit(n)] = v;
    return t;
  endfunction
  function automatic logic [7:0] nxt_of(input int a);
    if (a == 0) return 8'h80;
    if (a >= 128) return is_w(a % 16) ? 8'(16 + a % 16) : bbase(a % 16);
    if (a >= 16 && a <= 29 && is_w(a - 16)) return 8'(128 + a - 16 + 1);
    for (int n = 0; n < 16; n++)
      if (!is_w(n) && (8'(a) == bexp(n, 1'b0) || 8'(a) == bexp(n, 1'b1)))
        return (n == 15) ? 8'h00 : 8'(128 + n + 1);
    return 8'h00;
  endfunction
  function automatic logic [DEPTH*WW-1:0] build_img();
    logic [DEPTH*WW-1:0] img;
    for (int a = 0; a < DEPTH; a++) img[a*WW +: WW] = {fctl(8'(a)), nxt_of(a)};
    return img;
  endfunction
  localparam logic [DEPTH*WW-1:0] IMG = build_img();

  logic clk = 0, rst = 1;
  logic [15:0] cv = '0;
  logic [CW-1:0] ctrl;
  logic [AW-1:0] upc;
  int n_run = 0, n_fail = 0;
  bit done = 0;

  always #5 clk = ~clk;

  mseq_top #(.AW(AW), .CW(CW), .ROM_IMAGE(IMG)) u0 (
    .clk(clk), .rst(rst),
    .cyc15_i(cv[0]), .hcyc7_i(cv[1] | cv[13]), .host_stb_i(cv[3]),
    .sync_found_i(cv[7]), .host_req_i(cv[8]), .sector_found_i(cv[9]),
    .sector_pulse_i(cv[10]), .hcyc12_i(cv[12]), .drive_wr_i(cv[2]),
    .crc_zero_i(cv[4]), .addr_sel_i(cv[5]), .addr_eq_i(cv[6]),
    .cache_end_i(cv[11]), .cmd_ok_i(cv[14]), .format_i(cv[15]),
    .ctrl_o(ctrl), .upc_o(upc)
  );

  task automatic tick();
    @(posedge clk); #2;
  endtask

  task automatic chk(input string rq, input logic [31:0] act, input logic [31:0] exp);
    n_run++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %0h expected %0h", rq, act, exp);
    end
  endtask

  task automatic at(input logic [7:0] a, input string rq);
    chk(rq, 32'(upc), 32'(a));
    chk("R2", 32'(ctrl), 32'(fctl(a)));
  endtask

  function automatic logic [15:0] others(input int n);
    logic [15:0] m;
    m = 16'hFFFF;
    m[n] = 1'b0;
    if (n == 1 || n == 13) begin m[1] = 1'b0; m[13] = 1'b0; end
    return m;
  endfunction

  task automatic t_reset();
    rst = 1; cv = '0;
    tick(); at(8'h00, "R1");
    tick(); at(8'h00, "R1");
    rst = 0;
    tick(); at(8'h80, "R1");
  endtask

  // Walk all sixteen slots starting at 0x80; ends at 0x00
  task automatic t_lap(input bit quick);
    for (int n = 0; n < 16; n++) begin
      logic [7:0] s;
      s = 8'(128 + n);
      if (is_w(n)) begin
        if (!quick) begin
          cv = '0;        tick(); at(s, "R5");
          cv = others(n); tick(); at(s, "R9");
          cv = '0; cv[n] = 1'b1;
          tick(); at(8'(16 + n), "R4");
        end else begin
          tick(); at(8'(16 + n), "R6");
        end
      end else begin
        cv = quick ? others(n) : 16'h0000;
        cv[n] = !quick;
        tick();
        at(bexp(n, !quick), (bbase(n)[bbit(n)]) ? "R8" : (quick ? "R9" : "R7"));
      end
      cv = '0;
      if (quick && n < 15 && is_w(n + 1)) cv[n + 1] = 1'b1;
      tick();
      at((n == 15) ? 8'h00 : 8'(128 + n + 1), "R3");
    end
  endtask

  task automatic t_enter(input bit pre);
    cv = '0; cv[0] = pre;
    tick(); at(8'h80, "R3");
  endtask

  task automatic t_reset_mid();
    cv = '0;
    tick(); at(8'h80, "R5");
    rst = 1;
    tick(); at(8'h00, "R1");
    rst = 0;
    tick(); at(8'h80, "R1");
  endtask

  initial begin
    t_reset();
    t_lap(1'b0);
    t_enter(1'b1);
    t_lap(1'b1);
    t_enter(1'b0);
    t_reset_mid();
    done = 1;
    $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

  initial begin
    #(200000 * 10);
    if (!done) begin
      n_run++; n_fail++;
      $display("FAIL watchdog: actual hung expected done");
      $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
    end
  end
endmodule